// File: doc/BRIEF.md
# Page-Load and Timed Nonvolatile Write Controller

This block manages the write path of a one-wire, bus-cycle driven serial memory. A cycle decoder ahead of it turns raw bus cycles into single-clock events: a recognised reset sequence, a write cycle carrying one bit, a read cycle, and a protocol error. From the order of those events alone, with no opcodes, the controller arms a write-enable latch, shifts in a 16-bit address, and collects whole data bytes into a 32-byte page buffer. It then waits for the start pattern and runs a timed write that hands the page to the array in one step.

A reset sequence arms the latch, but only while the write-protect input is high. Address bits arrive most significant first. Data bytes land at the address's offset within its page and advance with wraparound inside that page. The start pattern is a read, then a write of 1, then a read. An incomplete or out-of-order sequence clears the latch and leaves the block idle until the next reset sequence. While the timed write runs, the status bit reads 0 and every event is ignored. When the write ends, the whole page leaves in a single-cycle commit with a byte mask, the status bit returns to 1, and the latch clears.

Top module: `nvw_ctrl`

## Requirements
- R1: After reset, armed is 0, busy is 0, status is 1 and commit is 0.
- R2: A reset event sets armed in the following cycle only when wp_n is 1. While wp_n is 0, armed is cleared in the following cycle and any load in progress is dropped, so a later start pattern does nothing.
- R3: Reset, 16 write events (address, MSB first), whole bytes of write events (MSB first), then read, write with bit 1, read: busy is 1 in the cycle after the last read. At commit, commit_page equals address bits 15..5, and byte k of the load appears at page byte (address[4:0]+k) mod 32, in commit_data bits [8*i+7:8*i] for page byte i with commit_mask bit i set. Only loaded bytes have mask bits set.
- R4: Loading more than 32 bytes wraps within the page, and the byte loaded last at a page position is the one committed.
- R5: A read ending the load after a bit count that is not a multiple of 8 starts no write and clears armed.
- R6: A read during the address phase, or a read right after the 16 address bits with no data loaded, starts no write and clears armed.
- R7: A second read after the read that ends the load clears armed, and no write starts.
- R8: A protocol error event outside a running write clears armed and abandons the load.
- R9: busy stays 1 for exactly WRITE_CYCLES cycles, with status 0 throughout. When busy falls, commit pulses for one cycle, status returns to 1 and armed is 0.
- R10: While busy, reset, write, read and error events, and wp_n falling, change neither the duration nor the committed page, and armed is still 0 after the commit.
- R11: Without a preceding reset event, write and read events do not arm the block or start a write.
- R12: In the start pattern, a write with bit 0 in place of bit 1 starts no write and clears armed. A following reset event arms the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write protect, low blocks arming and new writes |
| evt_reset | input | 1 | Decoder saw a complete reset sequence |
| evt_write | input | 1 | Decoder saw a write cycle |
| evt_bit | input | 1 | Data-line value for evt_write |
| evt_read | input | 1 | Decoder saw a read cycle |
| evt_error | input | 1 | Decoder saw an illegal cycle order |
| armed | output | 1 | Write-enable latch |
| busy | output | 1 | Timed write in progress |
| status | output | 1 | Value a read returns: 0 while busy, else 1 |
| commit | output | 1 | One-cycle array write strobe |
| commit_page | output | ADDR_W-5 | Page number being written |
| commit_data | output | 8*PAGE_BYTES | Page contents, byte i in bits 8i+7..8i |
| commit_mask | output | PAGE_BYTES | Page bytes that were loaded |

## Verification
The hardest case to reach is a running write being disturbed. To get there, the stimulus must first complete a full armed load and start pattern, and then fire reset, write, read and error events and drop write protect, all inside the short busy window. The bench shortens WRITE_CYCLES to 12 so that these disturbances fit inside the window. It measures the busy length with its own cycle counter, so the length is checked no matter what else happens during the write. Wraparound is reached by loading 33 and 45 bytes from offsets that are not on a page boundary, with expected page contents computed arithmetically.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // disarmed, waiting for a reset sequence
        ST_ADDR,   // shifting address bits
        ST_DATA,   // shifting data bits into the page
        ST_RD1,    // load closed by one read
        ST_RD1W,   // read then write-1 seen
        ST_BUSY    // timed write running
    } nvw_state_e;
endpackage

// File: rtl/nvw_seq.sv
module nvw_seq
    import nvw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wp_n,
    input  logic                    evt_reset,
    input  logic                    evt_write,
    input  logic                    evt_bit,
    input  logic                    evt_read,
    input  logic                    evt_error,
    input  logic                    buf_aligned,
    input  logic                    buf_has_data,
    input  logic                    tmr_done,
    output logic                    buf_clear,
    output logic                    buf_ptr_load,
    output logic [OFS_W-1:0]        buf_ptr_val,
    output logic                    buf_shift,
    output logic                    tmr_start,
    output logic                    armed_o,
    output logic                    busy_o,
    output logic                    status_o,
    output logic                    commit_o,
    output logic [ADDR_W-OFS_W-1:0] page_o
);
    localparam int ACNT_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        nvw_state_e          st;
        logic                armed;
        logic                status;
        logic                commit;
        logic [ADDR_W-1:0]   addr;
        logic [ACNT_W-1:0]   acnt;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, armed: 1'b0, status: 1'b1,
                                 commit: 1'b0, addr: '0, acnt: '0};

    seq_t              q, d;
    logic [ADDR_W-1:0] addr_nx;
    logic              in_busy;

    always_comb begin
        d            = q;
        d.commit     = 1'b0;
        buf_clear    = 1'b0;
        buf_ptr_load = 1'b0;
        buf_shift    = 1'b0;
        tmr_start    = 1'b0;
        addr_nx      = {q.addr[ADDR_W-2:0], evt_bit};
        buf_ptr_val  = addr_nx[OFS_W-1:0];
        in_busy      = (q.st == ST_BUSY);

        case (q.st)
            ST_ADDR: begin
                if (evt_write) begin
                    d.addr = addr_nx;
                    d.acnt = q.acnt + 1'b1;
                    if (q.acnt == ACNT_W'(ADDR_W - 1)) begin
                        d.st         = ST_DATA;
                        buf_ptr_load = 1'b1;
                    end
                end else if (evt_read) begin
                    d.st    = ST_IDLE;
                    d.armed = 1'b0;
                end
            end
            ST_DATA: begin
                if (evt_write) begin
                    buf_shift = 1'b1;
                end else if (evt_read) begin
                    if (buf_aligned && buf_has_data) begin
                        d.st = ST_RD1;
                    end else begin
                        d.st    = ST_IDLE;
                        d.armed = 1'b0;
                    end
                end
            end
            ST_RD1: begin
                if (evt_write && evt_bit) begin
                    d.st = ST_RD1W;
                end else if (evt_write || evt_read) begin
                    d.st    = ST_IDLE;
                    d.armed = 1'b0;
                end
            end
            ST_RD1W: begin
                if (evt_read && q.armed) begin
                    d.st      = ST_BUSY;
                    d.status  = 1'b0;
                    tmr_start = 1'b1;
                end else if (evt_read || evt_write) begin
                    d.st    = ST_IDLE;
                    d.armed = 1'b0;
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    d.st     = ST_IDLE;
                    d.status = 1'b1;
                    d.commit = 1'b1;
                    d.armed  = 1'b0;
                end
            end
            default: ;
        endcase

        // Sequence-level events apply only outside a running write
        if (!in_busy) begin
            if (evt_error) begin
                d.st    = ST_IDLE;
                d.armed = 1'b0;
            end
            if (evt_reset) begin
                if (wp_n) begin
                    d.st      = ST_ADDR;
                    d.armed   = 1'b1;
                    d.acnt    = '0;
                    buf_clear = 1'b1;
                end else begin
                    d.st    = ST_IDLE;
                    d.armed = 1'b0;
                end
            end
        end

        // Write protect holds the latch clear; a running write continues
        if (!wp_n) begin
            d.armed = 1'b0;
            if (!in_busy) begin
                d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign armed_o  = q.armed;
    assign busy_o   = (q.st == ST_BUSY);
    assign status_o = q.status;
    assign commit_o = q.commit;
    assign page_o   = q.addr[ADDR_W-1:OFS_W];
endmodule

// File: rtl/nvw_page.sv
module nvw_page #(
    parameter  int PAGE_BYTES = 32,
    localparam int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    ptr_load,
    input  logic [OFS_W-1:0]        ptr_val,
    input  logic                    shift,
    input  logic                    bit_in,
    output logic                    aligned,
    output logic                    has_data,
    output logic [8*PAGE_BYTES-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o
);
    typedef struct packed {
        logic [OFS_W-1:0]                ptr;
        logic [2:0]                      bcnt;
        logic [6:0]                      sh;
        logic                            has;
        logic [PAGE_BYTES-1:0]           mask;
        logic [PAGE_BYTES-1:0][7:0]      data;
    } page_t;

    page_t                 q, d;
    logic                  byte_done;
    logic [7:0]            new_byte;
    logic [PAGE_BYTES-1:0] lane_we;

    // One write-enable per byte lane, selected by the wrapping pointer
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign lane_we[g] = byte_done && (q.ptr == OFS_W'(g));
    end

    always_comb begin
        d         = q;
        byte_done = 1'b0;
        new_byte  = {q.sh, bit_in};
        if (clear) begin
            d.mask = '0;
            d.has  = 1'b0;
            d.bcnt = '0;
            d.sh   = '0;
        end else begin
            if (ptr_load) begin
                d.ptr = ptr_val;
            end
            if (shift) begin
                d.sh   = new_byte[6:0];
                d.bcnt = q.bcnt + 1'b1;
                if (q.bcnt == 3'd7) begin
                    byte_done = 1'b1;
                    d.has     = 1'b1;
                    d.ptr     = q.ptr + 1'b1;
                end
            end
        end
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (lane_we[i]) begin
                d.data[i] = new_byte;
                d.mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign aligned  = (q.bcnt == 3'd0);
    assign has_data = q.has;
    assign data_o   = q.data;
    assign mask_o   = q.mask;
endmodule

// File: rtl/nvw_timer.sv
module nvw_timer #(
    parameter  int CYCLES = 250000,
    localparam int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run_o,
    output logic done_o
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.run = 1'b1;
            d.cnt = CNT_W'(CYCLES - 1);
        end else if (q.run) begin
            if (q.cnt == '0) begin
                d.run = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o  = q.run;
    assign done_o = q.run && (q.cnt == '0);
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl #(
    parameter  int ADDR_W       = 16,
    parameter  int PAGE_BYTES   = 32,
    parameter  int WRITE_CYCLES = 250000,
    localparam int OFS_W        = $clog2(PAGE_BYTES),
    localparam int PAGE_W       = ADDR_W - OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wp_n,
    input  logic                    evt_reset,
    input  logic                    evt_write,
    input  logic                    evt_bit,
    input  logic                    evt_read,
    input  logic                    evt_error,
    output logic                    armed,
    output logic                    busy,
    output logic                    status,
    output logic                    commit,
    output logic [PAGE_W-1:0]       commit_page,
    output logic [8*PAGE_BYTES-1:0] commit_data,
    output logic [PAGE_BYTES-1:0]   commit_mask
);
    logic             buf_clear;
    logic             buf_ptr_load;
    logic [OFS_W-1:0] buf_ptr_val;
    logic             buf_shift;
    logic             buf_aligned;
    logic             buf_has_data;
    logic             tmr_start;
    logic             tmr_run;
    logic             tmr_done;

    nvw_seq #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_n         (wp_n),
        .evt_reset    (evt_reset),
        .evt_write    (evt_write),
        .evt_bit      (evt_bit),
        .evt_read     (evt_read),
        .evt_error    (evt_error),
        .buf_aligned  (buf_aligned),
        .buf_has_data (buf_has_data),
        .tmr_done     (tmr_done),
        .buf_clear    (buf_clear),
        .buf_ptr_load (buf_ptr_load),
        .buf_ptr_val  (buf_ptr_val),
        .buf_shift    (buf_shift),
        .tmr_start    (tmr_start),
        .armed_o      (armed),
        .busy_o       (busy),
        .status_o     (status),
        .commit_o     (commit),
        .page_o       (commit_page)
    );

    nvw_page #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .ptr_load (buf_ptr_load),
        .ptr_val  (buf_ptr_val),
        .shift    (buf_shift),
        .bit_in   (evt_bit),
        .aligned  (buf_aligned),
        .has_data (buf_has_data),
        .data_o   (commit_data),
        .mask_o   (commit_mask)
    );

    nvw_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run_o  (tmr_run),
        .done_o (tmr_done)
    );
endmodule

// File: rtl/nvw_ctrl_chk.sv
module nvw_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wp_n,
    input logic armed,
    input logic busy,
    input logic status,
    input logic commit,
    input logic tmr_run,
    input logic tmr_done
);
    assert_status_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !status);

    assert_status_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> status);

    assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_commit_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!busy && $past(busy)));

    assert_commit_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !armed);

    assert_wp_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !armed);

    assert_start_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> armed);

    assert_busy_timer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> tmr_run);

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> busy);
endmodule

bind nvw_ctrl nvw_ctrl_chk i_nvw_ctrl_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .armed    (armed),
    .busy     (busy),
    .status   (status),
    .commit   (commit),
    .tmr_run  (tmr_run),
    .tmr_done (tmr_done)
);

// File: tb/test_nvw_ctrl.sv
module test_nvw_ctrl;
    localparam int AW = 16;
    localparam int PB = 32;
    localparam int WC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic evt_reset = 1'b0, evt_write = 1'b0, evt_bit = 1'b0;
    logic evt_read = 1'b0, evt_error = 1'b0;
    logic armed, busy, status, commit;
    logic [AW-6:0]   commit_page;
    logic [8*PB-1:0] commit_data;
    logic [PB-1:0]   commit_mask;

    nvw_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) i_nvw_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .evt_reset(evt_reset), .evt_write(evt_write), .evt_bit(evt_bit),
        .evt_read(evt_read), .evt_error(evt_error),
        .armed(armed), .busy(busy), .status(status), .commit(commit),
        .commit_page(commit_page), .commit_data(commit_data), .commit_mask(commit_mask)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    logic [7:0]    exp_b [PB];
    logic [PB-1:0] exp_m;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic rs, input logic wr, input logic bt, input logic rd, input logic er);
        @(negedge clk);
        evt_reset = rs; evt_write = wr; evt_bit = bt; evt_read = rd; evt_error = er;
        @(negedge clk);
        evt_reset = 1'b0; evt_write = 1'b0; evt_bit = 1'b0; evt_read = 1'b0; evt_error = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) pulse(1'b0, 1'b1, v[i], 1'b0, 1'b0);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        for (int i = AW - 1; i >= 0; i--) pulse(1'b0, 1'b1, a[i], 1'b0, 1'b0);
    endtask

    // Reset sequence, address, then nb bytes; fills the expected page
    task automatic load(input logic [AW-1:0] a, input int nb, input int seed);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_addr(a);
        exp_m = '0;
        for (int k = 0; k < nb; k++) begin
            int idx;
            logic [7:0] v;
            idx = (int'(a[4:0]) + k) % PB;
            v = 8'((seed + k * 37) & 255);
            exp_b[idx] = v;
            exp_m[idx] = 1'b1;
            send_byte(v);
        end
    endtask

    task automatic start_seq(input logic wbit);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b1, wbit, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic finish_write(input logic [AW-1:0] a, input int t0, input string req);
        int g;
        bit ok;
        int bad_i;
        g = 0;
        while (busy && g < 1000) begin
            @(negedge clk);
            g++;
        end
        chk(cyc - t0 == WC, "R9 busy length", cyc - t0, WC);
        chk(commit == 1'b1, "R9 commit at busy fall", commit, 1);
        chk(status == 1'b1, "R9 status after write", status, 1);
        chk(armed == 1'b0, "R9 latch cleared at end", armed, 0);
        chk(commit_page == a[AW-1:5], {req, " page number"}, commit_page, a[AW-1:5]);
        chk(commit_mask == exp_m, {req, " byte mask"}, commit_mask, exp_m);
        ok = 1'b1;
        bad_i = 0;
        for (int i = 0; i < PB; i++) begin
            if (exp_m[i] && commit_data[i*8 +: 8] != exp_b[i] && ok) begin
                ok = 1'b0;
                bad_i = i;
            end
        end
        chk(ok, {req, " page data"}, commit_data[bad_i*8 +: 8], exp_b[bad_i]);
        @(negedge clk);
        chk(commit == 1'b0, "R9 commit one cycle", commit, 0);
    endtask

    task automatic full_write(input logic [AW-1:0] a, input int nb, input int seed, input string req);
        int t0;
        load(a, nb, seed);
        start_seq(1'b1);
        t0 = cyc;
        chk(busy == 1'b1, "R3 busy after start pattern", busy, 1);
        chk(status == 1'b0, "R9 status low while busy", status, 0);
        finish_write(a, t0, req);
    endtask

    task automatic expect_none(input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < WC + 4; i++) begin
            @(negedge clk);
            if (busy || commit) seen = 1'b1;
        end
        chk(!seen, {req, " no write started"}, seen, 0);
        chk(armed == 1'b0, {req, " latch clear"}, armed, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] addrs [4];
        int nbs [3];
        int t0;
        addrs[0] = 16'h0000; addrs[1] = 16'h1234; addrs[2] = 16'h3FFF; addrs[3] = 16'h00E5;
        nbs[0] = 1; nbs[1] = 8; nbs[2] = 32;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(armed == 1'b0, "R1 armed", armed, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(status == 1'b1, "R1 status", status, 1);
        chk(commit == 1'b0, "R1 commit", commit, 0);

        // R11 cycles without a reset sequence do nothing
        send_addr(16'h0040);
        send_byte(8'hA5);
        start_seq(1'b1);
        expect_none("R11");

        // R2 arming and write protect
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(armed == 1'b1, "R2 reset arms latch", armed, 1);
        wp_n = 1'b0;
        @(negedge clk);
        chk(armed == 1'b0, "R2 wp low clears latch", armed, 0);
        wp_n = 1'b1;
        @(negedge clk);
        chk(armed == 1'b0, "R2 latch stays clear", armed, 0);
        wp_n = 1'b0;
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(armed == 1'b0, "R2 reset ignored under wp", armed, 0);
        wp_n = 1'b1;
        load(16'h0100, 2, 3);
        @(negedge clk) wp_n = 1'b0;
        @(negedge clk) wp_n = 1'b1;
        start_seq(1'b1);
        expect_none("R2 wp glitch during load");

        // R3 sweep of addresses and lengths
        for (int ai = 0; ai < 4; ai++) begin
            for (int ni = 0; ni < 3; ni++) begin
                full_write(addrs[ai], nbs[ni], ai * 17 + ni * 5 + 1, "R3");
            end
        end

        // R4 wraparound within page
        full_write(16'h0105, 33, 11, "R4");
        full_write(16'h2A1F, 45, 200, "R4");

        // R5 partial byte
        load(16'h0200, 2, 7);
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        start_seq(1'b1);
        expect_none("R5");

        // R6 read during address
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(armed == 1'b0, "R6 read in address clears latch", armed, 0);
        for (int i = 0; i < 9; i++) pulse(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        send_byte(8'h3C);
        start_seq(1'b1);
        expect_none("R6 read in address");
        // R6 no data bytes
        load(16'h0300, 0, 0);
        start_seq(1'b1);
        expect_none("R6 empty load");

        // R7 two reads then write
        load(16'h0400, 3, 9);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(armed == 1'b0, "R7 second read clears latch", armed, 0);
        pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_none("R7");

        // R8 protocol error mid load
        load(16'h0500, 2, 21);
        pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(armed == 1'b0, "R8 error clears latch", armed, 0);
        send_byte(8'h81);
        start_seq(1'b1);
        expect_none("R8");

        // R12 write of 0 in start pattern, then re-arm and write
        load(16'h0600, 2, 33);
        start_seq(1'b0);
        expect_none("R12");
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(armed == 1'b1, "R12 reset re-arms", armed, 1);
        full_write(16'h0647, 4, 77, "R12 follow-up");

        // R10 disturbances during a running write
        load(16'h2A47, 5, 99);
        start_seq(1'b1);
        t0 = cyc;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(busy == 1'b1 && status == 1'b0, "R10 still busy mid write", busy, 1);
        wp_n = 1'b0;
        finish_write(16'h2A47, t0, "R10");
        wp_n = 1'b1;
        @(negedge clk);
        chk(armed == 1'b0, "R10 reset during write did not arm", armed, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule